// File: doc/BRIEF.md
# Power Switch Drive Sequencer

This block converts an on/off command into a single protected drive-enable bit for one power switch. The command arrives either as a level (`pulse_mode` = 0) or as separate set and reset pulses that load an internal command latch (`pulse_mode` = 1). Pulses that are too short are filtered out. After a rising command edge, the sequencer waits a programmable delay. It then drives the switch for a guaranteed minimum window. After that window it holds the switch on until one of these events: the command falls, a maximum conduction time runs out, a fault appears or a blocking condition appears.

Fault flags come from external detectors as single bits. Overcurrent, desaturation and overtemperature faults are latched into a one-hot cause vector. Undervoltage, inhibit and the optional negative-supply check act as unlatched blocks. In both cases the sequencer returns to idle, so the switch conducts at most once per command period. Every timer value is given as a cycle count.

The controller has four states:

| State | Drive | Leaves when |
|---|---|---|
| `ST_IDLE` | off | Goes to `ST_DELAY` on a rising command edge, which also clears the cause vector. |
| `ST_DELAY` | off | When its counter expires, it goes to `ST_MINON` if nothing stops conduction. Otherwise it goes back to `ST_IDLE`. |
| `ST_MINON` | on | When its counter expires, it goes to `ST_ON`, or to `ST_IDLE` if a stop condition is present. |
| `ST_ON` | on | Goes to `ST_IDLE` on any stop condition. |

Top module: `pwr_drive_seq`

## Requirements
- R1: In level mode, with the command sampled high first at clock edge 0 and `dly_cyc` = D, `drive_en` is first high after edge 1+max(D,1). If the command is no longer high at the edge before that, no conduction occurs.
- R2: Once `drive_en` rises, it stays high for at least max(`min_on_cyc`,1) cycles. During that window no fault, block, command fall or maximum-time expiry turns it off.
- R3: With `max_on_cyc` = X and X ≠ 0, conduction lasts at most max(X, `min_on_cyc`, 1) cycles. X = 0 disables the limit.
- R4: When the level command is sampled low at edge H during `ST_ON`, `drive_en` is low after edge H+1.
- R5: The fault cause vector has these bits: bit 0 for overcurrent, bit 1 for desaturation, bit 2 for overtemperature. A fault seen while the sequencer is out of `ST_IDLE` latches its bit. Overcurrent has the highest priority and overtemperature the lowest. The latched fault ends conduction at the next edge, once the minimum window is over. The vector never has more than one bit set.
- R6: Desaturation is sampled only in `ST_ON`. During the delay and the minimum window it has no effect on either `drive_en` or the cause vector.
- R7: Undervoltage, inhibit and (when enabled) negative-supply-low end `ST_ON` at the next edge and abort a start at the end of the delay. They do not set a cause bit and are not remembered, so a later rising edge conducts normally once they clear.
- R8: With `neg_chk_en` = 0, `negsup_low` has no effect on `drive_en`.
- R9: In pulse mode, a set or reset input qualifies only after it has been high for `pw_min` consecutive cycles. A value of 0 counts as 1. Shorter pulses are ignored. A qualified set raises the internal command and a qualified reset lowers it. If both qualify together, the reset wins.
- R10: The cause vector clears at the edge where a rising command edge moves `ST_IDLE` to `ST_DELAY`.
- R11: After reset, `drive_en` is 0 and the cause vector is 0.
- R12: After conduction ends for any reason, `drive_en` stays low while the command remains high. Only a new rising command edge starts another period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_mode | input | 1 | 0: level command, 1: set/reset pulse command |
| cmd_lvl | input | 1 | Level command |
| set_pulse | input | 1 | Pulse-mode turn-on request |
| rst_pulse | input | 1 | Pulse-mode turn-off request |
| pw_min | input | PWW | Minimum qualifying pulse width in cycles |
| dly_cyc | input | TW | Turn-on delay in cycles |
| min_on_cyc | input | TW | Minimum conduction window in cycles |
| max_on_cyc | input | TW | Maximum conduction time in cycles, 0 = unlimited |
| neg_chk_en | input | 1 | Enables the negative-supply check |
| ocp_flt | input | 1 | Overcurrent flag |
| desat_flt | input | 1 | Desaturation flag |
| negsup_low | input | 1 | Negative supply low flag |
| uvlo_flt | input | 1 | Positive supply undervoltage flag |
| otemp_flt | input | 1 | Overtemperature flag |
| inhibit | input | 1 | Forces the drive off |
| drive_en | output | 1 | Drive enable for the power switch |
| fault_cause | output | FLT_N | One-hot latched fault cause |

## Verification
The properties assume that the fault flags and timer inputs are synchronous to `clk`. They also assume that the timer configuration stays constant for the whole conduction period; the delay and window counters load their values only at state entry. The stimulus changes every input only at the falling clock edge. It reprograms the timer values only after the sequencer has sat idle for longer than any period can last. In pulse mode it never lets a set and a reset pulse overlap, except in the one case that checks the reset-wins rule.

// File: rtl/pds_pkg.sv
package pds_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_MINON = 2'd2,
        ST_ON    = 2'd3
    } pds_state_e;

    localparam int FLT_N     = 3;
    localparam int FLT_OCP   = 0;
    localparam int FLT_DESAT = 1;
    localparam int FLT_OTEMP = 2;
endpackage

// File: rtl/pds_pulse_qual.sv
module pds_pulse_qual #(
    parameter int PWW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           din,
    input  logic [PWW-1:0] pw_min,
    output logic           qual
);
    localparam logic [PWW-1:0] ONE     = PWW'(1);
    localparam logic [PWW-1:0] CNT_TOP = '1;

    logic [PWW-1:0] run_cnt;
    logic [PWW-1:0] pw_eff;

    assign pw_eff = (pw_min == '0) ? ONE : pw_min;
    assign qual   = en && din && (run_cnt == (pw_eff - ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!en || !din) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_TOP) begin
            run_cnt <= run_cnt + ONE;
        end
    end
endmodule

// File: rtl/pds_cmd_front.sv
module pds_cmd_front #(
    parameter int PWW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pulse_mode,
    input  logic           cmd_lvl,
    input  logic           set_pulse,
    input  logic           rst_pulse,
    input  logic [PWW-1:0] pw_min,
    output logic           cmd_q
);
    localparam int N_SRC = 2;

    logic [N_SRC-1:0] raw;
    logic [N_SRC-1:0] qual;
    logic             lvl_q;
    logic             sr_q;

    assign raw = {rst_pulse, set_pulse};

    for (genvar g = 0; g < N_SRC; g++) begin : g_qual
        pds_pulse_qual #(.PWW(PWW)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (pulse_mode),
            .din   (raw[g]),
            .pw_min(pw_min),
            .qual  (qual[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            sr_q  <= 1'b0;
        end else begin
            lvl_q <= cmd_lvl;
            if (!pulse_mode)  sr_q <= 1'b0;
            else if (qual[1]) sr_q <= 1'b0;
            else if (qual[0]) sr_q <= 1'b1;
        end
    end

    assign cmd_q = pulse_mode ? sr_q : lvl_q;

    // R9
    rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && qual[1]) |=> !sr_q);
endmodule

// File: rtl/pds_fault_latch.sv
module pds_fault_latch
    import pds_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm,
    input  logic             desat_arm,
    input  logic             ocp_flt,
    input  logic             desat_flt,
    input  logic             otemp_flt,
    output logic [FLT_N-1:0] cause,
    output logic             hit
);
    logic [FLT_N-1:0] seen;
    logic [FLT_N-1:0] pick;

    always_comb begin
        seen            = '0;
        seen[FLT_OCP]   = arm && ocp_flt;
        seen[FLT_DESAT] = desat_arm && desat_flt;
        seen[FLT_OTEMP] = arm && otemp_flt;
        pick            = seen & (~seen + FLT_N'(1));
    end

    assign hit = |seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cause <= '0;
        else if (clr)           cause <= '0;
        else if (cause == '0)   cause <= pick;
    end

    // R5
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause));

    // R5
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause != '0 && !clr) |=> $stable(cause));
endmodule

// File: rtl/pwr_drive_seq.sv
module pwr_drive_seq
    import pds_pkg::*;
#(
    parameter int TW  = 16,
    parameter int PWW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_mode,
    input  logic             cmd_lvl,
    input  logic             set_pulse,
    input  logic             rst_pulse,
    input  logic [PWW-1:0]   pw_min,
    input  logic [TW-1:0]    dly_cyc,
    input  logic [TW-1:0]    min_on_cyc,
    input  logic [TW-1:0]    max_on_cyc,
    input  logic             neg_chk_en,
    input  logic             ocp_flt,
    input  logic             desat_flt,
    input  logic             negsup_low,
    input  logic             uvlo_flt,
    input  logic             otemp_flt,
    input  logic             inhibit,
    output logic             drive_en,
    output logic [FLT_N-1:0] fault_cause
);
    localparam logic [TW-1:0] ONE = TW'(1);

    pds_state_e    state, nxt;
    logic          cmd_q, cmd_d, rise;
    logic [TW-1:0] cnt, mx;
    logic          block, hit, max_exp, stop_base, stop_on, tmo;

    pds_cmd_front #(.PWW(PWW)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_mode(pulse_mode),
        .cmd_lvl   (cmd_lvl),
        .set_pulse (set_pulse),
        .rst_pulse (rst_pulse),
        .pw_min    (pw_min),
        .cmd_q     (cmd_q)
    );

    pds_fault_latch u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == ST_IDLE && rise),
        .arm      (state != ST_IDLE),
        .desat_arm(state == ST_ON),
        .ocp_flt  (ocp_flt),
        .desat_flt(desat_flt),
        .otemp_flt(otemp_flt),
        .cause    (fault_cause),
        .hit      (hit)
    );

    assign rise      = cmd_q && !cmd_d;
    assign block     = uvlo_flt || inhibit || (neg_chk_en && negsup_low);
    assign tmo       = (cnt <= ONE);
    assign max_exp   = (max_on_cyc != '0) && (mx <= ONE);
    assign stop_base = !cmd_q || (fault_cause != '0) || hit || block;
    assign stop_on   = stop_base || max_exp;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (rise) nxt = ST_DELAY;
            ST_DELAY: if (tmo)  nxt = stop_base ? ST_IDLE : ST_MINON;
            ST_MINON: if (tmo)  nxt = stop_on ? ST_IDLE : ST_ON;
            ST_ON:    if (stop_on) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd_d <= 1'b0;
        end else begin
            state <= nxt;
            cmd_d <= cmd_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mx  <= '0;
        end else if (state == ST_IDLE && rise) begin
            cnt <= dly_cyc;
        end else if (state == ST_DELAY && nxt == ST_MINON) begin
            cnt <= min_on_cyc;
            mx  <= max_on_cyc;
        end else begin
            if (cnt != '0) cnt <= cnt - ONE;
            if ((state == ST_MINON || state == ST_ON) && mx != '0) mx <= mx - ONE;
        end
    end

    always_comb begin
        drive_en = (state == ST_MINON) || (state == ST_ON);
    end

    // R2
    min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MINON && cnt > ONE) |=> drive_en);

    // R7
    block_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && block) |=> !drive_en);

    // R5
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && fault_cause != '0) |=> state == ST_IDLE);

    // R6
    desat_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MINON && desat_flt && !ocp_flt && !otemp_flt && fault_cause == '0)
        |=> fault_cause == '0);

    // R12
    rise_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> $past(state) == ST_DELAY);
endmodule

// File: tb/tb_pwr_drive_seq.sv
module tb_pwr_drive_seq;
    localparam int  CLK_P = 10;
    localparam int  TW    = 16;
    localparam int  PWW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_mode = 1'b0, cmd_lvl = 1'b0, set_pulse = 1'b0, rst_pulse = 1'b0;
    logic [PWW-1:0] pw_min = PWW'(3);
    logic [TW-1:0]  dly_cyc = '0, min_on_cyc = '0, max_on_cyc = '0;
    logic neg_chk_en = 1'b0, ocp_flt = 1'b0, desat_flt = 1'b0, negsup_low = 1'b0;
    logic uvlo_flt = 1'b0, otemp_flt = 1'b0, inhibit = 1'b0;
    logic drive_en;
    logic [2:0] fault_cause;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pwr_drive_seq #(.TW(TW), .PWW(PWW)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .cmd_lvl(cmd_lvl),
        .set_pulse(set_pulse), .rst_pulse(rst_pulse), .pw_min(pw_min),
        .dly_cyc(dly_cyc), .min_on_cyc(min_on_cyc), .max_on_cyc(max_on_cyc),
        .neg_chk_en(neg_chk_en), .ocp_flt(ocp_flt), .desat_flt(desat_flt),
        .negsup_low(negsup_low), .uvlo_flt(uvlo_flt), .otemp_flt(otemp_flt),
        .inhibit(inhibit), .drive_en(drive_en), .fault_cause(fault_cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // rising level command with D=1: returns after edge 2 (first drive cycle)
    task automatic go_on();
        cmd_lvl = 1'b0;
        ticks(5);
        cmd_lvl = 1'b1;
        ticks(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        ticks(3);
        chk("R11 drive after reset", int'(drive_en), 0);
        chk("R11 cause after reset", int'(fault_cause), 0);
        rst_n = 1'b1;
        ticks(2);

        // Sweep: delay, minimum window, maximum time, command length
        for (int d = 0; d < 4; d++) begin
            for (int m = 0; m < 4; m++) begin
                for (int x = 0; x < 6; x++) begin
                    for (int h = 1; h <= 8; h++) begin
                        int s, mm, endc, lim, first, len, explen;
                        dly_cyc = TW'(d);
                        min_on_cyc = TW'(m);
                        max_on_cyc = TW'(x);
                        cmd_lvl = 1'b0;
                        ticks(3);
                        cmd_lvl = 1'b1;
                        first = -1;
                        len = 0;
                        for (int i = 0; i < 30; i++) begin
                            @(negedge clk);
                            if (drive_en) begin
                                len++;
                                if (first < 0) first = i;
                            end
                            cmd_lvl = (i + 1 < h);
                        end
                        s  = 1 + ((d > 1) ? d : 1);
                        mm = (m > 1) ? m : 1;
                        if (s > h) begin
                            explen = 0;
                        end else begin
                            lim = h + 1;
                            if (x != 0 && s + x < lim) lim = s + x;
                            endc = (s + mm > lim) ? s + mm : lim;
                            explen = endc - s;
                        end
                        chk("R2 R3 R4 conduction length", len, explen);
                        if (explen > 0) chk("R1 first drive edge", first, s);
                    end
                end
            end
        end

        dly_cyc = TW'(1);
        min_on_cyc = TW'(2);
        max_on_cyc = '0;

        // Overcurrent in ON
        go_on();
        chk("R1 drive on", int'(drive_en), 1);
        ticks(2);
        ocp_flt = 1'b1;
        ticks(1);
        ocp_flt = 1'b0;
        chk("R5 ocp stops drive", int'(drive_en), 0);
        chk("R5 ocp cause", int'(fault_cause), 1);
        ticks(4);
        chk("R12 no second pulse", int'(drive_en), 0);

        // Overcurrent inside minimum window
        go_on();
        chk("R10 cause cleared", int'(fault_cause), 0);
        ocp_flt = 1'b1;
        ticks(1);
        ocp_flt = 1'b0;
        chk("R2 ocp held off in window", int'(drive_en), 1);
        chk("R5 ocp latched in window", int'(fault_cause), 1);
        ticks(1);
        chk("R2 stop at window end", int'(drive_en), 0);

        // Desaturation blanked in window, active in ON
        go_on();
        desat_flt = 1'b1;
        ticks(2);
        desat_flt = 1'b0;
        chk("R6 desat blanked drive", int'(drive_en), 1);
        chk("R6 desat blanked cause", int'(fault_cause), 0);
        ticks(1);
        chk("R6 still on", int'(drive_en), 1);
        desat_flt = 1'b1;
        ticks(1);
        desat_flt = 1'b0;
        chk("R6 desat stops in ON", int'(drive_en), 0);
        chk("R5 desat cause", int'(fault_cause), 2);

        // Priority
        go_on();
        ticks(2);
        ocp_flt = 1'b1;
        otemp_flt = 1'b1;
        ticks(1);
        ocp_flt = 1'b0;
        otemp_flt = 1'b0;
        chk("R5 priority cause", int'(fault_cause), 1);
        chk("R5 priority drive", int'(drive_en), 0);

        // Overtemperature held, then resume
        go_on();
        ticks(2);
        otemp_flt = 1'b1;
        ticks(1);
        chk("R5 otemp cause", int'(fault_cause), 4);
        chk("R5 otemp drive", int'(drive_en), 0);
        go_on();
        chk("R5 otemp blocks start", int'(drive_en), 0);
        ticks(1);
        chk("R5 otemp relatched", int'(fault_cause), 4);
        otemp_flt = 1'b0;
        go_on();
        chk("R5 resume after otemp", int'(drive_en), 1);
        chk("R10 cleared after otemp", int'(fault_cause), 0);

        // Undervoltage
        ticks(2);
        uvlo_flt = 1'b1;
        ticks(1);
        chk("R7 uvlo stops", int'(drive_en), 0);
        chk("R7 uvlo no cause", int'(fault_cause), 0);
        uvlo_flt = 1'b0;
        ticks(3);
        chk("R12 off after uvlo clears", int'(drive_en), 0);
        go_on();
        uvlo_flt = 1'b1;
        ticks(1);
        chk("R2 uvlo in window", int'(drive_en), 1);
        ticks(1);
        chk("R7 uvlo at window end", int'(drive_en), 0);
        go_on();
        chk("R7 uvlo blocks start", int'(drive_en), 0);
        uvlo_flt = 1'b0;
        go_on();
        chk("R7 uvlo not latched", int'(drive_en), 1);

        // Inhibit
        ticks(2);
        inhibit = 1'b1;
        ticks(1);
        chk("R7 inhibit stops", int'(drive_en), 0);
        inhibit = 1'b0;

        // Negative supply check enable
        go_on();
        ticks(2);
        negsup_low = 1'b1;
        ticks(3);
        chk("R8 neg check disabled", int'(drive_en), 1);
        neg_chk_en = 1'b1;
        ticks(1);
        chk("R7 neg check enabled", int'(drive_en), 0);
        negsup_low = 1'b0;
        neg_chk_en = 1'b0;

        // Pulse mode
        cmd_lvl = 1'b0;
        ticks(4);
        pulse_mode = 1'b1;
        pw_min = PWW'(3);
        set_pulse = 1'b1;
        ticks(2);
        set_pulse = 1'b0;
        ticks(6);
        chk("R9 short set ignored", int'(drive_en), 0);
        set_pulse = 1'b1;
        ticks(3);
        set_pulse = 1'b0;
        ticks(3);
        chk("R9 qualified set", int'(drive_en), 1);
        ticks(4);
        rst_pulse = 1'b1;
        ticks(2);
        rst_pulse = 1'b0;
        ticks(4);
        chk("R9 short reset ignored", int'(drive_en), 1);
        rst_pulse = 1'b1;
        ticks(3);
        rst_pulse = 1'b0;
        ticks(2);
        chk("R9 qualified reset", int'(drive_en), 0);
        pw_min = '0;
        ticks(2);
        set_pulse = 1'b1;
        ticks(1);
        set_pulse = 1'b0;
        ticks(4);
        chk("R9 zero width as one", int'(drive_en), 1);
        rst_pulse = 1'b1;
        ticks(1);
        rst_pulse = 1'b0;
        ticks(3);
        chk("R9 one cycle reset", int'(drive_en), 0);
        pw_min = PWW'(3);
        ticks(2);
        set_pulse = 1'b1;
        rst_pulse = 1'b1;
        ticks(3);
        set_pulse = 1'b0;
        rst_pulse = 1'b0;
        ticks(4);
        chk("R9 reset wins", int'(drive_en), 0);
        pulse_mode = 1'b0;
        ticks(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule